// File: doc/BRIEF.md
# Lane pattern link-training sequencer

This controller brings up a 24-lane link organised as two halves: lanes 0 to 11 form the even half and lanes 12 to 23 form the odd half. Software chooses which halves take part and pulses a start input. If the link is marked inactive, the run ends at once. Otherwise the controller first sends a clock-recovery training pattern. On the first run after reset it then screens every lane: it drives a square wave and powers down the lanes that are never used. After a settling delay it asks an external checker, one lane at a time, whether the square wave arrived.

A lane that fails is passed to an external power-down engine. A lane that passes gets a one-cycle restore strobe, which returns its receive settings to defaults. A sticky flag records that screening has run, so later starts skip it. Every run that reaches the training phase resends the clock-recovery pattern and then raises a start-training bit for each enabled half.

All long waits come from one programmable cycle count, so a simulation can use short values. Both external blocks use a level request that stays high until a one-cycle acknowledge.

Top module: `lane_train_seq`

## Requirements
- R1: The per-half pattern code is 2'b00 for none, 2'b01 for the training sequence and 2'b10 for the square wave; 2'b11 never appears. Each training-sequence burst lasts delay_cycles+1 cycles. A half whose enable bit is clear (half_en[0] even, half_en[1] odd) shows 2'b00 for the whole run.
- R2: On a screening run the enabled halves show this code sequence: 01, 00 for one cycle, 10 while unused lanes are powered down, the delay runs and lanes are checked, 00 for one cycle, 01, then 00.
- R3: During screening, lanes 11 and 12 are always sent to the power-down engine. Each lane is requested at most once per run.
- R4: During screening, every lane of a disabled half is powered down unless recovery is high. With recovery high, lanes of a disabled half are neither powered down nor checked.
- R5: The checker sees only lanes 0 to 10 when the even half is enabled and lanes 13 to 23 when the odd half is enabled, in ascending lane order.
- R6: A lane whose check returns chk_pass low gets a power-down request. A lane whose check returns chk_pass high gets exactly one restore_stb cycle with lane_sel equal to that lane.
- R7: The screened output rises at the end of the first active run and stays high until reset. While it is high, an active run sends only the training-sequence burst, with no square wave, no requests and no restore strobes.
- R8: An active run ends with start_train equal to the latched half_en and a one-cycle done pulse. start_train clears at the next start.
- R9: A start with link_active low gives done in the cycle after start is sampled, with no pattern, no request, start_train at 0 and screened unchanged.
- R10: An acknowledge that arrives with pdn_timeout high sets error and the sequence continues. error clears at the next start.
- R11: After reset the patterns are 00, all requests and strobes are low, and start_train, screened, busy, done and error are 0.
- R12: chk_req and pdn_req are never high together. Each request holds, with lane_sel stable, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when idle |
| link_active | input | 1 | Low skips the whole run |
| half_en | input | 2 | Bit 0 even half, bit 1 odd half |
| recovery | input | 1 | Keeps the lanes of a disabled half powered |
| delay_cycles | input | 32 | Length of each long wait, minus one |
| tx_pat_even | output | 2 | Transmit pattern code for the even half |
| tx_pat_odd | output | 2 | Transmit pattern code for the odd half |
| lane_sel | output | 5 | Lane addressed by the current request or strobe |
| chk_req | output | 1 | Check request to the pattern checker |
| chk_ack | input | 1 | Checker acknowledge |
| chk_pass | input | 1 | Check result, valid with chk_ack |
| pdn_req | output | 1 | Request to the power-down engine |
| pdn_ack | input | 1 | Power-down acknowledge |
| pdn_timeout | input | 1 | Power-down engine timed out, valid with pdn_ack |
| restore_stb | output | 1 | Restore receive defaults for lane_sel |
| start_train | output | 2 | Link-layer training start, one bit per half |
| screened | output | 1 | Sticky flag: screening has run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | A power-down timeout was seen in this run |

## Verification
The bench targets the half-boundary lanes, the recovery mode with one half disabled, the all-disabled case, zero-length delays and the second run after screening. A design that checked the boundary lanes would show them in the check log. One that ignored recovery would power down a disabled half, and one that did not latch the ran-once flag would screen a second time. The responders stall for a random number of cycles, so a request that dropped early or changed lane while waiting would lose or duplicate a lane in the logs. Timeout injection on a chosen lane shows whether error is raised, whether the run keeps going, and whether a later run clears it.

// File: rtl/lane_train_seq.sv
module lane_train_seq #(
  parameter int NUM_LANES = 24,
  parameter int DLY_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         link_active,
  input  logic [1:0]                   half_en,
  input  logic                         recovery,
  input  logic [DLY_W-1:0]             delay_cycles,
  output logic [1:0]                   tx_pat_even,
  output logic [1:0]                   tx_pat_odd,
  output logic [$clog2(NUM_LANES)-1:0] lane_sel,
  output logic                         chk_req,
  input  logic                         chk_ack,
  input  logic                         chk_pass,
  output logic                         pdn_req,
  input  logic                         pdn_ack,
  input  logic                         pdn_timeout,
  output logic                         restore_stb,
  output logic [1:0]                   start_train,
  output logic                         screened,
  output logic                         busy,
  output logic                         done,
  output logic                         error
);
  localparam int LANE_W = $clog2(NUM_LANES);
  localparam int HALF   = NUM_LANES / 2;
  localparam logic [LANE_W-1:0] LO_EDGE = LANE_W'(HALF - 1);
  localparam logic [LANE_W-1:0] HI_EDGE = LANE_W'(HALF);
  localparam logic [LANE_W-1:0] LAST    = LANE_W'(NUM_LANES - 1);
  localparam logic [1:0] PAT_NONE = 2'b00;
  localparam logic [1:0] PAT_TS   = 2'b01;
  localparam logic [1:0] PAT_SQW  = 2'b10;

  typedef enum logic [3:0] {
    S_IDLE, S_LOCK1, S_GAP, S_PDN, S_WAIT, S_CHK, S_RST, S_CPDN, S_STOP, S_LOCK2, S_FIN
  } state_t;

  state_t            state;
  logic [LANE_W-1:0] lane_q;
  logic [DLY_W-1:0]  cnt_q;
  logic [1:0]        en_q, train_q;
  logic              rec_q, scr_q, err_q;
  logic              need_pdn, need_chk, last, cnt_zero;
  logic [1:0]        cur_pat;

  assign last     = (lane_q == LAST);
  assign cnt_zero = (cnt_q == '0);
  assign need_pdn = (lane_q == LO_EDGE) || (lane_q == HI_EDGE) ||
                    (!rec_q && !en_q[0] && lane_q < LO_EDGE) ||
                    (!rec_q && !en_q[1] && lane_q > HI_EDGE);
  assign need_chk = (en_q[0] && lane_q < LO_EDGE) || (en_q[1] && lane_q > HI_EDGE);

  always_comb begin
    case (state)
      S_LOCK1, S_LOCK2:                     cur_pat = PAT_TS;
      S_PDN, S_WAIT, S_CHK, S_RST, S_CPDN:  cur_pat = PAT_SQW;
      default:                              cur_pat = PAT_NONE;
    endcase
  end

  assign tx_pat_even = en_q[0] ? cur_pat : PAT_NONE;
  assign tx_pat_odd  = en_q[1] ? cur_pat : PAT_NONE;
  assign lane_sel    = lane_q;
  assign chk_req     = (state == S_CHK) && need_chk;
  assign pdn_req     = ((state == S_PDN) && need_pdn) || (state == S_CPDN);
  assign restore_stb = (state == S_RST);
  assign start_train = train_q;
  assign screened    = scr_q;
  assign busy        = (state != S_IDLE);
  assign done        = (state == S_FIN);
  assign error       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      lane_q  <= '0;
      cnt_q   <= '0;
      en_q    <= '0;
      rec_q   <= 1'b0;
      train_q <= '0;
      scr_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (pdn_req && pdn_ack && pdn_timeout) err_q <= 1'b1;
      case (state)
        S_IDLE: if (start) begin
          en_q    <= half_en;
          rec_q   <= recovery;
          train_q <= '0;
          err_q   <= 1'b0;
          cnt_q   <= delay_cycles;
          if (!link_active) state <= S_FIN;
          else              state <= scr_q ? S_LOCK2 : S_LOCK1;
        end
        S_LOCK1: if (cnt_zero) state <= S_GAP; else cnt_q <= cnt_q - 1'b1;
        S_GAP: begin
          lane_q <= '0;
          state  <= S_PDN;
        end
        S_PDN: if (!need_pdn || pdn_ack) begin
          if (last) begin
            lane_q <= '0;
            cnt_q  <= delay_cycles;
            state  <= S_WAIT;
          end else lane_q <= lane_q + 1'b1;
        end
        S_WAIT: if (cnt_zero) state <= S_CHK; else cnt_q <= cnt_q - 1'b1;
        S_CHK: begin
          if (!need_chk) begin
            if (last) begin lane_q <= '0; state <= S_STOP; end
            else lane_q <= lane_q + 1'b1;
          end else if (chk_ack) state <= chk_pass ? S_RST : S_CPDN;
        end
        S_RST, S_CPDN: if (state == S_RST || pdn_ack) begin
          if (last) begin lane_q <= '0; state <= S_STOP; end
          else begin lane_q <= lane_q + 1'b1; state <= S_CHK; end
        end
        S_STOP: begin
          scr_q <= 1'b1;
          cnt_q <= delay_cycles;
          state <= S_LOCK2;
        end
        S_LOCK2: if (cnt_zero) begin
          train_q <= en_q;
          state   <= S_FIN;
        end else cnt_q <= cnt_q - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_req_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_req && pdn_req));
  assert_pdn_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_req && !pdn_ack) |=> (pdn_req && $stable(lane_sel)));
  assert_chk_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !chk_ack) |=> (chk_req && $stable(lane_sel)));
  assert_no_edge_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> (lane_sel != LO_EDGE && lane_sel != HI_EDGE));
  assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pat_even != 2'b11) && (tx_pat_odd != 2'b11));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!chk_req && !pdn_req && !restore_stb && tx_pat_even == PAT_NONE && tx_pat_odd == PAT_NONE));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    screened |=> screened);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_lane_train_seq.sv
module test_lane_train_seq;
  localparam int NL = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, link_active = 0, recovery = 0;
  logic [1:0] half_en = 0;
  logic [31:0] delay_cycles = 0;
  logic [1:0] tx_pat_even, tx_pat_odd, start_train;
  logic [4:0] lane_sel;
  logic chk_req, chk_ack = 0, chk_pass = 0;
  logic pdn_req, pdn_ack = 0, pdn_timeout = 0;
  logic restore_stb, screened, busy, done, error;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [NL-1:0] pass_mask = '1;
  int to_lane = -1;
  logic [NL-1:0] pdn_log, chk_log, rst_log;
  int pdn_cnt, chk_cnt, last_chk;
  bit order_bad;
  int pdn_wait = 0, chk_wait = 0;

  bit mon_en = 0;
  logic [1:0] last_code;
  logic [31:0] trace_v;
  int tn, ts_cnt;
  bit dis_bad;
  bit tb_scr = 0;

  always #4 clk = ~clk;

  lane_train_seq i_lane_train_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .link_active(link_active),
    .half_en(half_en), .recovery(recovery), .delay_cycles(delay_cycles),
    .tx_pat_even(tx_pat_even), .tx_pat_odd(tx_pat_odd), .lane_sel(lane_sel),
    .chk_req(chk_req), .chk_ack(chk_ack), .chk_pass(chk_pass),
    .pdn_req(pdn_req), .pdn_ack(pdn_ack), .pdn_timeout(pdn_timeout),
    .restore_stb(restore_stb), .start_train(start_train), .screened(screened),
    .busy(busy), .done(done), .error(error));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] f_unused(input logic [1:0] en, input bit rec);
    logic [NL-1:0] m = '0;
    for (int l = 0; l < NL; l++)
      m[l] = (l == NL/2-1) || (l == NL/2) || (!rec && !en[0] && l < NL/2-1) || (!rec && !en[1] && l > NL/2);
    return m;
  endfunction

  function automatic logic [NL-1:0] f_chk(input logic [1:0] en);
    logic [NL-1:0] m = '0;
    for (int l = 0; l < NL; l++) m[l] = (en[0] && l < NL/2-1) || (en[1] && l > NL/2);
    return m;
  endfunction

  initial forever begin
    @(negedge clk);
    pdn_ack = 0; pdn_timeout = 0; chk_ack = 0; chk_pass = 0;
    if (restore_stb) rst_log[lane_sel] = 1'b1;
    if (pdn_req) begin
      if (pdn_wait == 0) begin
        pdn_ack = 1;
        pdn_timeout = (int'(lane_sel) == to_lane);
        if (pdn_log[lane_sel]) pdn_cnt += 100;
        pdn_log[lane_sel] = 1'b1;
        pdn_cnt++;
        pdn_wait = $urandom % 3;
      end else pdn_wait--;
    end
    if (chk_req) begin
      if (chk_wait == 0) begin
        chk_ack = 1;
        chk_pass = pass_mask[lane_sel];
        if (chk_cnt > 0 && int'(lane_sel) <= last_chk) order_bad = 1;
        last_chk = lane_sel;
        chk_log[lane_sel] = 1'b1;
        chk_cnt++;
        chk_wait = $urandom % 4;
      end else chk_wait--;
    end
  end

  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      if ((tx_pat_even | tx_pat_odd) != last_code) begin
        last_code = tx_pat_even | tx_pat_odd;
        trace_v = (trace_v << 2) | 32'(last_code);
        tn++;
      end
      if (tx_pat_even == 2'b01) ts_cnt++;
      if ((!half_en[0] && tx_pat_even != 0) || (!half_en[1] && tx_pat_odd != 0)) dis_bad = 1;
    end
  end

  task automatic do_reset();
    rst_n = 0; start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; tb_scr = 0;
    @(negedge clk);
  endtask

  task automatic run(input logic [1:0] en, input bit rec, input bit act,
                     input logic [NL-1:0] pass, input int to, input int d);
    bit scr_run = act && !tb_scr;
    logic [NL-1:0] e_chk = scr_run ? f_chk(en) : '0;
    logic [NL-1:0] e_pdn = scr_run ? (f_unused(en, rec) | (e_chk & ~pass)) : '0;
    logic [NL-1:0] e_rst = e_chk & pass;
    logic [37:0] e_tr;
    int e_ts;
    bit e_err = (to >= 0) && e_pdn[to];
    int wd = 0;
    half_en = en; recovery = rec; link_active = act; delay_cycles = d;
    pass_mask = pass; to_lane = to;
    pdn_log = '0; chk_log = '0; rst_log = '0; pdn_cnt = 0; chk_cnt = 0; order_bad = 0;
    last_code = 0; trace_v = 0; tn = 0; ts_cnt = 0; dis_bad = 0;
    mon_en = 1; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    mon_en = 0;
    check(done === 1'b1, "R8 done seen", 64'(done), 64'd1);
    if (!act) check(wd == 0, "R9 done next cycle", 64'(wd), 64'd0);
    if (!act || en == 0) e_tr = 0;
    else if (scr_run)    e_tr = {6'd6, 32'h484};
    else                 e_tr = {6'd2, 32'h4};
    check({6'(tn), trace_v} == e_tr, "R2 pattern sequence", {6'(tn), trace_v}, e_tr);
    e_ts = (act && en[0]) ? (scr_run ? 2 : 1) * (d + 1) : 0;
    check(ts_cnt == e_ts, "R1 burst length", 64'(ts_cnt), 64'(e_ts));
    check(!dis_bad, "R1 disabled half quiet", 64'(dis_bad), 64'd0);
    check(pdn_log == e_pdn, "R3 R4 R6 power-down lanes", 64'(pdn_log), 64'(e_pdn));
    check(pdn_cnt == $countones(e_pdn), "R3 one request per lane", 64'(pdn_cnt), 64'($countones(e_pdn)));
    check(chk_log == e_chk, "R5 checked lanes", 64'(chk_log), 64'(e_chk));
    check(!order_bad, "R5 ascending order", 64'(order_bad), 64'd0);
    check(rst_log == e_rst, "R6 restore lanes", 64'(rst_log), 64'(e_rst));
    check(start_train == (act ? en : 2'b00), "R8 start_train", 64'(start_train), 64'(act ? en : 2'b00));
    if (act) tb_scr = 1;
    check(screened == tb_scr, "R7 screened flag", 64'(screened), 64'(tb_scr));
    check(error == e_err, "R10 error flag", 64'(error), 64'(e_err));
    @(negedge clk);
    check(!busy && !done, "R8 done single cycle", {busy, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    check({tx_pat_even, tx_pat_odd, chk_req, pdn_req, restore_stb, start_train, screened, busy, done, error} == '0,
          "R11 reset state",
          {tx_pat_even, tx_pat_odd, chk_req, pdn_req, restore_stb, start_train, screened, busy, done, error}, 64'd0);
    run(2'b11, 0, 1, '1, -1, 3);
    run(2'b01, 0, 1, '1, -1, 2);
    run(2'b11, 0, 0, '1, -1, 2);
    do_reset();
    run(2'b11, 0, 0, '1, -1, 1);
    check(screened == 1'b0, "R9 screened unchanged", 64'(screened), 64'd0);
    run(2'b01, 0, 1, 24'hFFFBFE, -1, 0);
    do_reset();
    run(2'b10, 1, 1, 24'h7FFFFF, -1, 1);
    do_reset();
    run(2'b00, 0, 1, '1, -1, 0);
    do_reset();
    run(2'b11, 0, 1, 24'hFEFFFF, 11, 2);
    check(busy == 1'b0, "R10 run continued", 64'(busy), 64'd0);
    run(2'b11, 0, 1, '1, -1, 1);
    for (int t = 0; t < 14; t++) begin
      logic [1:0] en = 2'($urandom);
      bit rec = 1'($urandom);
      logic [NL-1:0] pass = ~(NL'($urandom) & NL'($urandom) & NL'($urandom));
      int to = ($urandom % 2) ? int'($urandom % NL) : -1;
      do_reset();
      run(en, rec, 1, pass, to, int'($urandom % 6));
      case ($urandom % 3)
        0: run(2'($urandom), 0, 1, '1, -1, int'($urandom % 4));
        1: run(2'($urandom), 1, 0, '1, -1, 2);
        default: ;
      endcase
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule